// File: doc/BRIEF.md
# LCD Display Timing Generator

This block produces the raster timing for a parallel RGB panel: horizontal and vertical sync, a data-enable window and the current pixel position, together with one-cycle start-of-frame and end-of-frame markers. It advances one pixel per clock, so it is meant to run in the pixel clock domain. The pixel clock itself, the fetch of pixel data and any panel-specific auxiliary strobes lie outside it. The auxiliary strobe outputs exist only so that the pins have a defined value, and they are held low.

Software programs the timing through a plain register write port. All positions count pixel clocks (horizontally) or lines (vertically) from the leading edge of sync. The sync width sets where the pulse ends, the active start and end give an absolute half-open window, and the total sets where the counter wraps. A write first lands in a pending copy. The whole pending set becomes active together at the next frame boundary, so a frame is never built from a mix of old and new values.

The block has no streaming data path. The write port is a single-cycle strobe with no back-pressure, and every write is accepted in the cycle it is presented.

Top module: `lcd_timing_gen`

## Requirements
- R1: While `rst_n` is low, x and y read 0 and `sof_o` is high. After reset the active timing is the parameter default set: horizontal sync 2, window 4..12, total 14; vertical sync 1, window 2..6, total 7. All polarities are active high and the rising edge is selected.
- R2: `x_o` counts 0 to (horizontal total − 1) and then wraps to 0. `y_o` advances by one on each wrap and returns to 0 after (vertical total − 1).
- R3: Horizontal sync is asserted while x is below the horizontal sync width. Config bit 11 set inverts `hsync_o` (active low).
- R4: Vertical sync is asserted while y is below the vertical sync width. Config bit 8 set inverts `vsync_o`.
- R5: Data enable is asserted only when start ≤ x < end and start ≤ y < end, for the horizontal and vertical windows respectively. Config bit 9 set inverts `de_o`.
- R6: Register addresses are: 0 config, 1 horizontal sync width, 2 vertical sync width, 3 totals, 4 horizontal window, 5 vertical window. In the totals register, bits 31:16 hold the horizontal total and bits 15:0 the vertical total. Each window register holds the start in bits 31:16 and the end in bits 15:0. Writes to addresses 6 and 7 have no effect.
- R7: Written values become active on the clock edge that wraps both counters to 0. A write presented in the last cycle of a frame takes effect only at the boundary after the next one.
- R8: `sof_o` is high exactly when x = 0 and y = 0.
- R9: `eof_o` is high exactly when x = (horizontal end − 1) and y = (vertical end − 1).
- R10: `pclk_fall_o` reflects config bit 10 of the active set. A value of 1 selects launch on the falling pixel clock edge.
- R11: All bits of `aux_strobe_o` are always 0.
- R12: Only bits 9:0 of a sync width write are kept. Bits 31:10 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 32 | Register write data |
| hsync_o | output | 1 | Horizontal sync, polarity applied |
| vsync_o | output | 1 | Vertical sync, polarity applied |
| de_o | output | 1 | Data enable, polarity applied |
| pclk_fall_o | output | 1 | Falling-edge launch select |
| x_o | output | 16 | Horizontal pixel counter |
| y_o | output | 16 | Vertical line counter |
| sof_o | output | 1 | Start-of-frame marker |
| eof_o | output | 1 | End-of-frame marker |
| aux_strobe_o | output | 4 | Auxiliary panel strobes, held inactive |

## Verification
The counters are registers and every other output is decoded from them and from the active set without a further stage. Each output therefore shows, in the same cycle, the state reached at the preceding clock edge. A register write changes nothing until the frame wrap that follows it. If the write arrives in the wrap cycle itself, the change is delayed by a whole frame. The bench updates its behavioural model at each rising edge and compares every output at the following falling edge, so model and design are always viewed at the same point, and the deferred-write cases are placed on known model cycles.

// File: rtl/lcd_tg_pkg.sv
package lcd_tg_pkg;
  parameter int CW = 16;
  parameter int SW = 10;
  parameter int AW = 3;
  parameter int DW = 32;

  typedef struct packed {
    logic          hs_low;
    logic          vs_low;
    logic          de_low;
    logic          pclk_fall;
    logic [SW-1:0] hsw;
    logic [SW-1:0] vsw;
    logic [CW-1:0] htot;
    logic [CW-1:0] vtot;
    logic [CW-1:0] hstart;
    logic [CW-1:0] hend;
    logic [CW-1:0] vstart;
    logic [CW-1:0] vend;
  } timing_t;

  typedef enum logic [AW-1:0] {
    A_CFG  = 3'd0,
    A_HSW  = 3'd1,
    A_VSW  = 3'd2,
    A_TOT  = 3'd3,
    A_HWIN = 3'd4,
    A_VWIN = 3'd5
  } reg_addr_e;
endpackage

// File: rtl/lcd_tg_regs.sv
module lcd_tg_regs
  import lcd_tg_pkg::*;
#(
  parameter timing_t DEFAULTS = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          commit,
  output timing_t       act
);
  localparam int HALF = DW / 2;

  timing_t pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= DEFAULTS;
    end else if (wr_en) begin
      case (wr_addr)
        A_CFG: begin
          pend.hs_low    <= wr_data[11];
          pend.pclk_fall <= wr_data[10];
          pend.de_low    <= wr_data[9];
          pend.vs_low    <= wr_data[8];
        end
        A_HSW: pend.hsw <= wr_data[SW-1:0];
        A_VSW: pend.vsw <= wr_data[SW-1:0];
        A_TOT: begin
          pend.htot <= wr_data[HALF +: CW];
          pend.vtot <= wr_data[0 +: CW];
        end
        A_HWIN: begin
          pend.hstart <= wr_data[HALF +: CW];
          pend.hend   <= wr_data[0 +: CW];
        end
        A_VWIN: begin
          pend.vstart <= wr_data[HALF +: CW];
          pend.vend   <= wr_data[0 +: CW];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      act <= DEFAULTS;
    else if (commit) act <= pend;
  end
endmodule

// File: rtl/lcd_tg_counter.sv
module lcd_tg_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  input  logic [W-1:0] total,
  output logic [W-1:0] cnt,
  output logic         at_last
);
  assign at_last = (cnt == total - W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= '0;
    else if (step)     cnt <= at_last ? '0 : cnt + W'(1);
  end
endmodule

// File: rtl/lcd_tg_decode.sv
module lcd_tg_decode
  import lcd_tg_pkg::*;
(
  input  timing_t       act,
  input  logic [CW-1:0] xc,
  input  logic [CW-1:0] yc,
  output logic          hsync,
  output logic          vsync,
  output logic          de,
  output logic          sof,
  output logic          eof
);
  logic hs_on, vs_on, h_in, v_in;

  always_comb begin
    hs_on = xc < CW'(act.hsw);
    vs_on = yc < CW'(act.vsw);
    h_in  = (xc >= act.hstart) && (xc < act.hend);
    v_in  = (yc >= act.vstart) && (yc < act.vend);
    hsync = hs_on ^ act.hs_low;
    vsync = vs_on ^ act.vs_low;
    de    = (h_in && v_in) ^ act.de_low;
    sof   = (xc == '0) && (yc == '0);
    eof   = (xc == act.hend - CW'(1)) && (yc == act.vend - CW'(1));
  end
endmodule

// File: rtl/lcd_timing_gen.sv
module lcd_timing_gen
  import lcd_tg_pkg::*;
#(
  parameter int DEF_HSW    = 2,
  parameter int DEF_HSTART = 4,
  parameter int DEF_HEND   = 12,
  parameter int DEF_HTOT   = 14,
  parameter int DEF_VSW    = 1,
  parameter int DEF_VSTART = 2,
  parameter int DEF_VEND   = 6,
  parameter int DEF_VTOT   = 7,
  parameter int AUX_N      = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [2:0]       wr_addr,
  input  logic [31:0]      wr_data,
  output logic             hsync_o,
  output logic             vsync_o,
  output logic             de_o,
  output logic             pclk_fall_o,
  output logic [15:0]      x_o,
  output logic [15:0]      y_o,
  output logic             sof_o,
  output logic             eof_o,
  output logic [AUX_N-1:0] aux_strobe_o
);
  localparam int NAX = 2;

  localparam timing_t DEFS = '{
    hs_low: 1'b0, vs_low: 1'b0, de_low: 1'b0, pclk_fall: 1'b0,
    hsw: SW'(DEF_HSW), vsw: SW'(DEF_VSW),
    htot: CW'(DEF_HTOT), vtot: CW'(DEF_VTOT),
    hstart: CW'(DEF_HSTART), hend: CW'(DEF_HEND),
    vstart: CW'(DEF_VSTART), vend: CW'(DEF_VEND)
  };

  timing_t       act_cfg;
  logic [CW-1:0] cnt   [NAX];
  logic [CW-1:0] tot   [NAX];
  logic          last  [NAX];
  logic          step  [NAX];
  logic          frame_wrap;

  assign tot[0] = act_cfg.htot;
  assign tot[1] = act_cfg.vtot;

  genvar g;
  generate
    for (g = 0; g < NAX; g++) begin : g_axis
      if (g == 0) begin : g_first
        assign step[g] = 1'b1;
      end else begin : g_next
        assign step[g] = step[g-1] & last[g-1];
      end
      lcd_tg_counter #(.W(CW)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .step    (step[g]),
        .total   (tot[g]),
        .cnt     (cnt[g]),
        .at_last (last[g])
      );
    end
  endgenerate

  assign frame_wrap = step[NAX-1] & last[NAX-1];

  lcd_tg_regs #(.DEFAULTS(DEFS)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .commit  (frame_wrap),
    .act     (act_cfg)
  );

  lcd_tg_decode u_dec (
    .act   (act_cfg),
    .xc    (cnt[0]),
    .yc    (cnt[1]),
    .hsync (hsync_o),
    .vsync (vsync_o),
    .de    (de_o),
    .sof   (sof_o),
    .eof   (eof_o)
  );

  assign x_o          = cnt[0];
  assign y_o          = cnt[1];
  assign pclk_fall_o  = act_cfg.pclk_fall;
  assign aux_strobe_o = '0;
endmodule

// File: rtl/lcd_tg_chk.sv
module lcd_tg_chk
  import lcd_tg_pkg::*;
(
  input logic          clk,
  input logic          rst_n,
  input logic [CW-1:0] x_i,
  input logic [CW-1:0] y_i,
  input logic          de_i,
  input logic          sof_i,
  input logic          eof_i,
  input timing_t       act_i
);
  // R2
  x_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && x_i != '0) |-> x_i == $past(x_i) + CW'(1));

  // R2
  y_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && y_i != $past(y_i)) |-> x_i == '0);

  // R8
  sof_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sof_i |-> (x_i == '0 && y_i == '0));

  // R7
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !(x_i == '0 && y_i == '0)) |-> $stable(act_i));

  // R5
  de_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (de_i ^ act_i.de_low) |-> (x_i >= act_i.hstart && x_i < act_i.hend &&
                               y_i >= act_i.vstart && y_i < act_i.vend));

  // R9
  eof_de_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eof_i && act_i.hend > act_i.hstart && act_i.vend > act_i.vstart)
      |-> (de_i ^ act_i.de_low));
endmodule

bind lcd_timing_gen lcd_tg_chk u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .x_i   (x_o),
  .y_i   (y_o),
  .de_i  (de_o),
  .sof_i (sof_o),
  .eof_i (eof_o),
  .act_i (act_cfg)
);

// File: tb/lcd_timing_gen_test.sv
module lcd_timing_gen_test;
  localparam int PER = 10;
  localparam int WATCHDOG = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        hsync_o, vsync_o, de_o, pclk_fall_o, sof_o, eof_o;
  logic [15:0] x_o, y_o;
  logic [3:0]  aux_strobe_o;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #(PER/2) clk = ~clk;

  lcd_timing_gen uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .hsync_o(hsync_o), .vsync_o(vsync_o), .de_o(de_o), .pclk_fall_o(pclk_fall_o),
    .x_o(x_o), .y_o(y_o), .sof_o(sof_o), .eof_o(eof_o), .aux_strobe_o(aux_strobe_o)
  );

  // behavioural model: six registers, pending and active copies
  logic [31:0] pend [6];
  logic [31:0] actv [6];
  int mh = 0;
  int mv = 0;

  function automatic void load_defaults();
    pend[0] = 32'h0;
    pend[1] = 32'd2;
    pend[2] = 32'd1;
    pend[3] = {16'd14, 16'd7};
    pend[4] = {16'd4, 16'd12};
    pend[5] = {16'd2, 16'd6};
    for (int i = 0; i < 6; i++) actv[i] = pend[i];
  endfunction

  function automatic int htot(); return int'(actv[3][31:16]); endfunction
  function automatic int vtot(); return int'(actv[3][15:0]);  endfunction

  initial load_defaults();

  always @(posedge clk) begin
    if (!rst_n) begin
      load_defaults();
      mh = 0;
      mv = 0;
    end else begin
      bit wrap_h, wrap_all;
      wrap_h   = (mh == htot() - 1);
      wrap_all = wrap_h && (mv == vtot() - 1);
      mh = wrap_h ? 0 : mh + 1;
      if (wrap_h) mv = (mv == vtot() - 1) ? 0 : mv + 1;
      if (wrap_all) for (int i = 0; i < 6; i++) actv[i] = pend[i];
      if (wr_en && wr_addr < 3'd6) pend[wr_addr] = wr_data;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  // compare every output on each falling edge
  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      int hsw, vsw, hs, he, vs, ve;
      logic e_hs, e_vs, e_de;
      hsw = int'(actv[1][9:0]);
      vsw = int'(actv[2][9:0]);
      hs = int'(actv[4][31:16]); he = int'(actv[4][15:0]);
      vs = int'(actv[5][31:16]); ve = int'(actv[5][15:0]);
      e_hs = (mh < hsw) ^ actv[0][11];
      e_vs = (mv < vsw) ^ actv[0][8];
      e_de = (mh >= hs && mh < he && mv >= vs && mv < ve) ^ actv[0][9];
      check("R2 R6 R7 x", {16'h0, x_o}, mh);
      check("R2 R6 R7 y", {16'h0, y_o}, mv);
      check("R3 R12 hsync", {31'h0, hsync_o}, {31'h0, e_hs});
      check("R4 vsync", {31'h0, vsync_o}, {31'h0, e_vs});
      check("R5 de", {31'h0, de_o}, {31'h0, e_de});
      check("R8 sof", {31'h0, sof_o}, {31'h0, (mh == 0 && mv == 0)});
      check("R9 eof", {31'h0, eof_o}, {31'h0, (mh == he - 1 && mv == ve - 1)});
      check("R10 pclk_fall", {31'h0, pclk_fall_o}, {31'h0, actv[0][10]});
      check("R11 aux", {28'h0, aux_strobe_o}, 32'h0);
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 reset x", {16'h0, x_o}, 32'h0);
    check("R1 reset y", {16'h0, y_o}, 32'h0);
    check("R1 reset sof", {31'h0, sof_o}, 32'h1);
    rst_n = 1'b1;
    // R1 defaults over two frames
    run(2 * 14 * 7 + 5);
    // mid-frame rewrite, R12 upper bits of sync width set
    wr(3'd1, 32'hFFFF_FC03);
    wr(3'd3, {16'd10, 16'd5});
    wr(3'd4, {16'd4, 16'd9});
    wr(3'd5, {16'd1, 16'd4});
    wr(3'd0, 32'h0000_0F00);
    // R6 unmapped address ignored
    wr(3'd6, 32'hFFFF_FFFF);
    wr(3'd7, 32'h0000_0001);
    run(3 * 14 * 7);
    // R7 write in the final cycle of a frame is deferred one frame
    while (!(mh == htot() - 1 && mv == vtot() - 1)) @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'd3; wr_data = {16'd12, 16'd6};
    @(negedge clk);
    wr_en = 1'b0;
    run(10);
    check("R7 totals held", {16'h0, actv[3][31:16]}, 32'd10);
    run(3 * 12 * 6);
    check("R7 totals applied", {16'h0, actv[3][31:16]}, 32'd12);
    // polarities back to active high, vertical sync wide
    wr(3'd0, 32'h0);
    wr(3'd2, 32'd2);
    run(3 * 12 * 6);
    done = 1'b1;
  end

  initial begin
    while (!done && cycles < WATCHDOG) @(negedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule